// File: doc/BRIEF.md
# Single-Step Reference Machine with State Load

This block is an unpipelined golden model of a small register machine. Each instruction is fully determined by the program counter. A combinational decoder derives the operation, two source register indices, a destination index and the next PC. A four-function ALU combines the two source operands. When told to step, the machine retires one whole instruction in a single clock cycle. Both operands are read from its own current register file.

A projection input overwrites the complete architectural state, meaning the PC and every register, from an external state port. Projection wins over stepping. A checking environment can therefore copy a pipelined machine's drained state into this model, step it once and compare. The current PC and the flattened register file are always visible at the outputs.

Top module: `ref_step_machine`

## Requirements
- R1: While reset is held and after its release, the PC equals PC_INIT (default 0) and register i holds (17*i + 3) mod 2^DATA_W.
- R2: When `project_i` is high at a clock edge, after that edge the PC equals `ld_pc_i` and every register equals its field of `ld_rf_i`, whatever the value of `step_i`. Register i occupies bits [i*DATA_W +: DATA_W].
- R3: When `step_i` is high and `project_i` is low, the PC becomes (PC + 1) mod 2^PC_W, so the highest PC wraps to 0.
- R4: On such a step the destination register receives the ALU result, and every other register keeps its value.
- R5: When both `step_i` and `project_i` are low, the PC and all registers hold.
- R6: For PC value p, the decode is: op = (3p + 1) mod 4, src1 = (5p + 2) mod 2^RA_W, src2 = 3p mod 2^RA_W, dest = (3p + 2) mod 2^RA_W.
- R7: The op codes are 0 = a + b, 1 = a - b, 2 = a AND b and 3 = a XOR b, all taken mod 2^DATA_W. Here a is the src1 value and b is the src2 value.
- R8: Both operands come from the register file as it stood before the step. When dest equals src1 (p = 0, 4, 8, 12), the old src1 value is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Retire one instruction this cycle |
| project_i | input | 1 | Overwrite PC and registers from the load port |
| ld_pc_i | input | PC_W | PC value to load |
| ld_rf_i | input | 2^RA_W * DATA_W | Register values to load, register i at [i*DATA_W +: DATA_W] |
| pc_o | output | PC_W | Current PC |
| rf_o | output | 2^RA_W * DATA_W | Current register file, same packing |

## Verification
The bench builds the block with its defaults: PC_W = 4, RA_W = 3 (8 registers) and DATA_W = 8. A 4-bit PC lets a run of steps visit all sixteen instruction slots, which exercises all four op codes and the wrap from 15 back to 0. With eight registers, the destination equals the first source at every fourth PC, which brings the read-before-write case within reach. Eight-bit data makes the add and subtract wrap reachable through projected values near 0 and 255.

// File: rtl/ref_pkg.sv
package ref_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } op_e;
endpackage

// File: rtl/ref_decode.sv
module ref_decode
  import ref_pkg::*;
#(
  parameter int PC_W = 4,
  parameter int RA_W = 3
) (
  input  logic [PC_W-1:0] pc_i,
  output op_e             op_o,
  output logic [RA_W-1:0] src1_o,
  output logic [RA_W-1:0] src2_o,
  output logic [RA_W-1:0] dest_o,
  output logic [PC_W-1:0] npc_o
);
  function automatic logic [RA_W-1:0] reg_sel(input logic [PC_W-1:0] p, input int mul, input int add);
    return RA_W'(int'(p) * mul + add);
  endfunction

  always_comb begin
    op_o   = op_e'(2'(int'(pc_i) * 3 + 1));
    src1_o = reg_sel(pc_i, 5, 2);
    src2_o = reg_sel(pc_i, 3, 0);
    dest_o = reg_sel(pc_i, 3, 2);
    npc_o  = pc_i + PC_W'(1);
  end
endmodule

// File: rtl/ref_alu.sv
module ref_alu
  import ref_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  function automatic logic [DATA_W-1:0] calc(input op_e op, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    unique case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      default: return a ^ b;
    endcase
  endfunction

  assign y_o = calc(op_i, a_i, b_i);
endmodule

// File: rtl/ref_regfile.sv
module ref_regfile #(
  parameter int RA_W   = 3,
  parameter int DATA_W = 8,
  localparam int NREG  = 1 << RA_W,
  localparam int FLAT_W = NREG * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [FLAT_W-1:0] load_data,
  input  logic              we,
  input  logic [RA_W-1:0]   wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [RA_W-1:0]   ra1,
  input  logic [RA_W-1:0]   ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2,
  output logic [FLAT_W-1:0] flat_o
);
  logic [DATA_W-1:0] mem [NREG];

  function automatic logic [DATA_W-1:0] init_val(input int idx);
    return DATA_W'(idx * 17 + 3);
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem[i] <= init_val(i);
      else if (load_en)                   mem[i] <= load_data[i*DATA_W +: DATA_W];
      else if (we && wa == RA_W'(i))      mem[i] <= wd;
    end
    assign flat_o[i*DATA_W +: DATA_W] = mem[i];

    // R4
    keep_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !load_en && wa != RA_W'(i)) |=> $stable(mem[i]));
  end

  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];

  // R4
  wr_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !load_en) |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/ref_step_machine.sv
module ref_step_machine
  import ref_pkg::*;
#(
  parameter int PC_W    = 4,
  parameter int RA_W    = 3,
  parameter int DATA_W  = 8,
  parameter int PC_INIT = 0,
  localparam int NREG   = 1 << RA_W,
  localparam int FLAT_W = NREG * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              project_i,
  input  logic [PC_W-1:0]   ld_pc_i,
  input  logic [FLAT_W-1:0] ld_rf_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [FLAT_W-1:0] rf_o
);
  logic [PC_W-1:0]   pc_q, npc;
  op_e               op;
  logic [RA_W-1:0]   s1, s2, dst;
  logic [DATA_W-1:0] a, b, y;
  logic              step_fire;

  assign step_fire = step_i && !project_i;

  ref_decode #(.PC_W(PC_W), .RA_W(RA_W)) u_dec (
    .pc_i(pc_q), .op_o(op), .src1_o(s1), .src2_o(s2), .dest_o(dst), .npc_o(npc)
  );

  ref_alu #(.DATA_W(DATA_W)) u_alu (.op_i(op), .a_i(a), .b_i(b), .y_o(y));

  ref_regfile #(.RA_W(RA_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .load_en(project_i), .load_data(ld_rf_i),
    .we(step_fire), .wa(dst), .wd(y), .ra1(s1), .ra2(s2),
    .rd1(a), .rd2(b), .flat_o(rf_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc_q <= PC_W'(PC_INIT);
    else if (project_i) pc_q <= ld_pc_i;
    else if (step_fire) pc_q <= npc;
  end

  assign pc_o = pc_q;

  // R2
  load_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    project_i |=> (pc_o == $past(ld_pc_i)) && (rf_o == $past(ld_rf_i)));
  // R3
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !project_i) |=> $stable(pc_o) && $stable(rf_o));
endmodule

// File: tb/tb_ref_step_machine.sv
module tb_ref_step_machine;
  localparam int PC_W = 4, RA_W = 3, DATA_W = 8;
  localparam int NREG = 1 << RA_W, PCN = 1 << PC_W, DMOD = 1 << DATA_W;

  logic clk = 0, rst_n = 0, step_i = 0, project_i = 0;
  logic [PC_W-1:0] ld_pc_i = '0;
  logic [NREG*DATA_W-1:0] ld_rf_i = '0;
  logic [PC_W-1:0] pc_o;
  logic [NREG*DATA_W-1:0] rf_o;

  int m_pc;
  int m_rf [NREG];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ref_step_machine dut (.clk(clk), .rst_n(rst_n), .step_i(step_i), .project_i(project_i),
    .ld_pc_i(ld_pc_i), .ld_rf_i(ld_rf_i), .pc_o(pc_o), .rf_o(rf_o));

  function automatic int alu_ref(int op, int a, int b);
    if (op == 0) return (a + b) % DMOD;
    if (op == 1) return (a - b + DMOD) % DMOD;
    if (op == 2) return a & b;
    return a ^ b;
  endfunction

  task automatic compare(string tag);
    n_cmp++;
    if (int'(pc_o) != m_pc) begin
      n_bad++;
      $display("FAIL %s pc: actual %0d expected %0d", tag, pc_o, m_pc);
    end
    for (int i = 0; i < NREG; i++) begin
      n_cmp++;
      if (int'(rf_o[i*DATA_W +: DATA_W]) != m_rf[i]) begin
        n_bad++;
        $display("FAIL %s reg%0d: actual %0d expected %0d", tag, i, rf_o[i*DATA_W +: DATA_W], m_rf[i]);
      end
    end
  endtask

  // one cycle: drive at negedge, update model, compare at next negedge
  task automatic cycle(bit st, bit pj, int lpc, bit rnd_rf, int fill);
    string tag;
    int p, op, a, b, d;
    step_i = st; project_i = pj; ld_pc_i = PC_W'(lpc);
    for (int i = 0; i < NREG; i++)
      ld_rf_i[i*DATA_W +: DATA_W] = rnd_rf ? DATA_W'($urandom) : DATA_W'(fill);
    if (pj) begin
      tag = "R2 load";
      m_pc = lpc % PCN;
      for (int i = 0; i < NREG; i++) m_rf[i] = int'(ld_rf_i[i*DATA_W +: DATA_W]);
    end else if (st) begin
      tag = "R3 R4 R6 R7 R8 step";
      p  = m_pc;
      op = (3*p + 1) % 4;
      a  = m_rf[(5*p + 2) % NREG];
      b  = m_rf[(3*p) % NREG];
      d  = (3*p + 2) % NREG;
      m_rf[d] = alu_ref(op, a, b);
      m_pc = (p + 1) % PCN;
    end else tag = "R5 idle";
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    m_pc = 0;
    for (int i = 0; i < NREG; i++) m_rf[i] = (17*i + 3) % DMOD;
    @(negedge clk); compare("R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); compare("R1 after release");
    // walk all sixteen slots plus wrap
    for (int k = 0; k < 20; k++) cycle(1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cycle(0, 0, 0, 1, 0);
    // projection together with step, then walk from a high PC across the wrap
    cycle(1, 1, 14, 0, 255);
    for (int k = 0; k < 6; k++) cycle(1, 0, 0, 0, 0);
    cycle(0, 1, 12, 0, 1);
    for (int k = 0; k < 5; k++) cycle(1, 0, 0, 0, 0);
    cycle(0, 1, 0, 0, 0);
    for (int k = 0; k < 4; k++) cycle(1, 0, 0, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 300; k++) begin
      int r = $urandom_range(0, 9);
      if (r == 0)      cycle(bit'($urandom), 1, $urandom_range(0, PCN-1), 1, 0);
      else if (r < 3)  cycle(0, 0, $urandom_range(0, PCN-1), 1, 0);
      else             cycle(1, 0, $urandom_range(0, PCN-1), 1, 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule